// File: doc/BRIEF.md
# Prioritized Interrupt Recognizer

This block is the interrupt recognition front end of a small 8-bit processor. It watches five request pins: one request that software cannot block, an edge-triggered restart request, two level-triggered restart requests and one general level-triggered request. Each pin has its own trigger rule. The edge-triggered restart request and the unblockable request each keep an edge latch. The block also holds three per-source mask bits and a global enable flag.

The core pulses `boundary` in the final clock state of an instruction. In that cycle the block looks at every request that qualifies. It registers the one with the highest priority, together with its fixed vector address. If the winner is the general request, the block raises a flag that tells the core to run acknowledge bus cycles instead of using a vector. The result stays on the outputs until the core pulses `ack`.

Software controls the block with an enable strobe, a disable strobe and a mask-write port that takes an accumulator byte. When a maskable request is taken, the global enable clears itself.

Top module: `prio_irq_front`

## Requirements
- R1: After reset, `irq_valid` is 0, `irq_src` is 0, the global enable is off and all three restart masks are set. No maskable request is recognized until software unmasks and enables it.
- R2: The unblockable request is recognized only when two things hold: a rising edge of `nmi_req` was latched in an earlier cycle, and `nmi_req` is still high at the boundary. The enable flag and the masks never block it. It gives vector 0x0024. After it is acknowledged, a new rising edge is needed before it can be recognized again.
- R3: When several requests qualify together, the winner follows this order from highest to lowest: unblockable, `irq75`, `irq65`, `irq55`, `gen_req`. `irq_src` is one-hot, with bit 4 for unblockable, bit 3 for 7.5, bit 2 for 6.5, bit 1 for 5.5 and bit 0 for general.
- R4: A rising edge on `irq75` sets a latch. The latch stays set while 7.5 is masked or disabled. It is cleared when the 7.5 request is acknowledged, or by a mask write with bit 4 set.
- R5: `irq65`, `irq55` and `gen_req` count only if they are high in the boundary cycle.
- R6: Requests are evaluated only in a cycle where `boundary` is high. A level request that rises and falls between boundaries is never reported.
- R7: `en_cmd` turns the global enable on and `dis_cmd` turns it off. When both are pulsed in the same cycle, the disable wins.
- R8: On a mask write, `mask_data` bits 0, 1 and 2 are the masks for 5.5, 6.5 and 7.5, where 1 means masked. These masks are loaded only when bit 3 is 1. Bit 4 clears the 7.5 latch.
- R9: Taking any maskable request clears the global enable. Taking the unblockable request leaves the global enable unchanged.
- R10: The vector is 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5. The general request gives vector 0 and raises `irq_inta`.
- R11: A reported result holds its values until `ack` is pulsed. Boundary pulses that arrive while a result is held are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Unblockable request, edge-and-level triggered |
| irq75 | input | 1 | Restart 7.5 request, rising-edge triggered |
| irq65 | input | 1 | Restart 6.5 request, level triggered |
| irq55 | input | 1 | Restart 5.5 request, level triggered |
| gen_req | input | 1 | General request, level triggered |
| boundary | input | 1 | Final clock state of an instruction |
| mask_we | input | 1 | Mask-write strobe |
| mask_data | input | 8 | Accumulator byte for a mask write |
| en_cmd | input | 1 | Global enable strobe |
| dis_cmd | input | 1 | Global disable strobe |
| ack | input | 1 | Core has taken the reported request |
| irq_valid | output | 1 | A result is being reported |
| irq_src | output | 5 | One-hot source of the reported request |
| irq_vector | output | 16 | Service address of the reported request |
| irq_inta | output | 1 | General request taken; acknowledge cycles needed |

## Verification
The block registers its result at the clock edge that samples `boundary`. The monitor therefore waits for that edge, steps a short delay past it, and compares all outputs against the queued expectation, including the case where no result is expected.

Edge-triggered pins set their latch at the first edge that sees them high. For this reason the driver always leaves one full cycle between raising such a pin and pulsing `boundary`. Mask writes, enables and acknowledges take effect at the edge where the strobe is seen, so the next boundary already sees them.

// File: rtl/prio_irq_front.sv
module prio_irq_front #(
  parameter int VEC_W = 16,
  parameter int MW = 8,
  parameter logic [VEC_W-1:0] VEC_NMI = 'h0024,
  parameter logic [VEC_W-1:0] VEC_R75 = 'h003C,
  parameter logic [VEC_W-1:0] VEC_R65 = 'h0034,
  parameter logic [VEC_W-1:0] VEC_R55 = 'h002C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             irq75,
  input  logic             irq65,
  input  logic             irq55,
  input  logic             gen_req,
  input  logic             boundary,
  input  logic             mask_we,
  input  logic [MW-1:0]    mask_data,
  input  logic             en_cmd,
  input  logic             dis_cmd,
  input  logic             ack,
  output logic             irq_valid,
  output logic [4:0]       irq_src,
  output logic [VEC_W-1:0] irq_vector,
  output logic             irq_inta
);
  localparam int NSRC = 5;
  localparam int B_LOAD = 3;
  localparam int B_CLR75 = 4;

  logic nmi_d, r75_d, nmi_edge, r75_lat, ie;
  logic [2:0] msk;
  logic [NSRC-1:0] pend, pick;
  logic [VEC_W-1:0] vec;

  wire nmi_rise = nmi_req & ~nmi_d;
  wire r75_rise = irq75 & ~r75_d;
  wire acked    = ack & irq_valid;
  wire mload    = mask_we & mask_data[B_LOAD];
  wire clr75    = (acked & irq_src[3]) | (mask_we & mask_data[B_CLR75]);

  assign pend = {nmi_edge & nmi_req,
                 ie & ~msk[2] & r75_lat,
                 ie & ~msk[1] & irq65,
                 ie & ~msk[0] & irq55,
                 ie & gen_req};

  always_comb begin
    pick = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (pend[i] && pick == '0) pick[i] = 1'b1;
  end

  always_comb begin
    unique case (1'b1)
      pick[4]: vec = VEC_NMI;
      pick[3]: vec = VEC_R75;
      pick[2]: vec = VEC_R65;
      pick[1]: vec = VEC_R55;
      default: vec = '0;
    endcase
  end

  wire take      = boundary & ~irq_valid & (pend != '0);
  wire take_mask = take & ~pick[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_d      <= 1'b0;
      r75_d      <= 1'b0;
      nmi_edge   <= 1'b0;
      r75_lat    <= 1'b0;
      ie         <= 1'b0;
      msk        <= 3'b111;
      irq_valid  <= 1'b0;
      irq_src    <= '0;
      irq_vector <= '0;
      irq_inta   <= 1'b0;
    end else begin
      nmi_d    <= nmi_req;
      r75_d    <= irq75;
      nmi_edge <= nmi_rise | (nmi_edge & ~(acked & irq_src[4]));
      r75_lat  <= r75_rise | (r75_lat & ~clr75);
      if (take_mask || dis_cmd) ie <= 1'b0;
      else if (en_cmd)          ie <= 1'b1;
      if (mload) msk <= mask_data[2:0];
      if (take) begin
        irq_valid  <= 1'b1;
        irq_src    <= pick;
        irq_vector <= vec;
        irq_inta   <= pick[0];
      end else if (acked) begin
        irq_valid  <= 1'b0;
        irq_src    <= '0;
        irq_vector <= '0;
        irq_inta   <= 1'b0;
      end
    end
  end

  a_r3_onehot_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ($onehot0(irq_src) && irq_src != '0));
  a_r2_nmi_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid) && irq_src[4]) |-> $past(nmi_req));
  a_r6_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(boundary));
  a_r9_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid) && irq_src[3:0] != '0) |-> !ie);
  a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_src) && $stable(irq_vector)));
  a_r8_gate_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !mask_data[B_LOAD]) |=> $stable(msk));
  a_r10_general_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_src[0]) |-> (irq_inta && irq_vector == '0));
endmodule

// File: tb/prio_irq_front_tb_top.sv
`timescale 1ns/1ps
module prio_irq_front_tb_top;
  typedef struct packed {
    logic        v;
    logic [4:0]  src;
    logic [15:0] vec;
    logic        inta;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic nmi_req = 0, irq75 = 0, irq65 = 0, irq55 = 0, gen_req = 0;
  logic boundary = 0, mask_we = 0, en_cmd = 0, dis_cmd = 0, ack = 0;
  logic [7:0] mask_data = 0;
  logic irq_valid, irq_inta;
  logic [4:0] irq_src;
  logic [15:0] irq_vector;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t q[$];
  string tq[$];

  always #5 clk = ~clk;

  prio_irq_front dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq75(irq75), .irq65(irq65),
    .irq55(irq55), .gen_req(gen_req), .boundary(boundary), .mask_we(mask_we),
    .mask_data(mask_data), .en_cmd(en_cmd), .dis_cmd(dis_cmd), .ack(ack),
    .irq_valid(irq_valid), .irq_src(irq_src), .irq_vector(irq_vector), .irq_inta(irq_inta));

  function automatic exp_t mk(int k);
    exp_t e;
    e = '0;
    case (k)
      1: e = '{1'b1, 5'b00001, 16'h0000, 1'b1};
      2: e = '{1'b1, 5'b00010, 16'h002C, 1'b0};
      3: e = '{1'b1, 5'b00100, 16'h0034, 1'b0};
      4: e = '{1'b1, 5'b01000, 16'h003C, 1'b0};
      5: e = '{1'b1, 5'b10000, 16'h0024, 1'b0};
      default: e = '0;
    endcase
    return e;
  endfunction

  task automatic chk(logic [22:0] act, logic [22:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && boundary) begin
      exp_t e;
      string t;
      #2;
      e = q.pop_front();
      t = tq.pop_front();
      chk({irq_valid, irq_src, irq_vector, irq_inta}, e, t);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic strobe(int k, string tag);
    q.push_back(mk(k));
    tq.push_back(tag);
    boundary = 1; tick(); boundary = 0;
  endtask
  task automatic do_ack;
    ack = 1; tick(); ack = 0;
  endtask
  task automatic do_en;
    en_cmd = 1; tick(); en_cmd = 0;
  endtask
  task automatic do_dis;
    dis_cmd = 1; tick(); dis_cmd = 0;
  endtask
  task automatic wmask(logic [7:0] d);
    mask_we = 1; mask_data = d; tick(); mask_we = 0; mask_data = 0;
  endtask
  task automatic pulse75;
    irq75 = 1; tick(); irq75 = 0; tick();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    chk({22'd0, irq_valid}, 23'd0, "R1 valid after reset");
    chk({18'd0, irq_src}, 23'd0, "R1 src after reset");
    gen_req = 1; irq55 = 1; tick();
    strobe(0, "R1 enable off after reset");
    gen_req = 0; do_en();
    strobe(0, "R1 masks set after reset");
    gen_req = 1; tick();
    strobe(1, "R10 R5 general request");
    do_ack();
    strobe(0, "R9 enable cleared after maskable take");
    gen_req = 0; irq55 = 0;

    wmask(8'h08); do_en();
    irq55 = 1; irq65 = 1; tick();
    strobe(3, "R3 6.5 over 5.5");
    do_ack(); do_en();
    strobe(3, "R5 6.5 level still high");
    do_ack(); irq65 = 0; do_en();
    strobe(2, "R10 5.5 vector");
    do_ack(); irq55 = 0; do_en();

    irq65 = 1; tick(); irq65 = 0; tick();
    strobe(0, "R6 level pulse between boundaries");
    irq65 = 1; tick(3);
    chk({22'd0, irq_valid}, 23'd0, "R6 no report without boundary");
    strobe(3, "R6 6.5 at boundary");
    do_ack(); irq65 = 0;

    wmask(8'h0C); do_en();
    pulse75();
    strobe(0, "R4 7.5 masked");
    wmask(8'h08);
    strobe(4, "R4 latch held through mask");
    do_ack(); do_en();
    strobe(0, "R4 latch cleared by ack");
    pulse75(); wmask(8'h10);
    strobe(0, "R8 bit4 clears 7.5 latch");
    wmask(8'h07);
    pulse75();
    strobe(4, "R8 bit3 low leaves masks");
    do_ack();

    do_en(); gen_req = 1; nmi_req = 1; tick();
    strobe(5, "R2 R3 unblockable over general");
    do_ack();
    strobe(1, "R9 R2 unblockable needs new edge, enable kept");
    do_ack(); gen_req = 0;
    nmi_req = 0; tick(); nmi_req = 1; tick(); nmi_req = 0; tick();
    strobe(0, "R2 level gone at boundary");

    do_en(); irq55 = 1; tick();
    strobe(2, "R11 5.5 reported");
    nmi_req = 1; tick();
    strobe(2, "R11 held while unacked");
    do_ack();
    strobe(5, "R11 unblockable after ack");
    do_ack(); nmi_req = 0; irq55 = 0;

    do_en(); do_dis(); gen_req = 1; tick();
    strobe(0, "R7 disable");
    en_cmd = 1; dis_cmd = 1; tick(); en_cmd = 0; dis_cmd = 0;
    strobe(0, "R7 disable wins over enable");
    do_en();
    strobe(1, "R7 enable");
    do_ack(); gen_req = 0;
    tick(2);

    chk({22'd0, q.size() == 0}, 23'd1, "scoreboard drained");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule